// File: doc/BRIEF.md
# Isolated Digital I/O Register Block

This block is a byte-wide register peripheral for sixteen latched digital outputs and sixteen digital inputs. The inputs come from off-chip and arrive asynchronously. The block synchronizes them and watches them for a change of state in either direction. When any input toggles, it records which half of the input word changed. If interrupts are enabled, it raises a level interrupt that stays high until software clears it.

A host reaches the block over a simple synchronous bus: a 3-bit address, a read strobe, a write strobe, write data and read data. Read data is a combinational function of the address. Some addresses have access side effects. Reading or writing them changes control state, and the data is ignored. Two control flags work this way:

- **Interrupt enable:** a read turns it on and a write turns it off.
- **Filter enable:** a read turns it on and a write turns it off.

A write to the low input-port address clears the pending change-of-state record. When a read strobe and a write strobe come in the same cycle, the access counts as a write.

Register map (byte addresses):

| Address | Read | Write |
|---|---|---|
| 0 | output lane 0 (outputs 7:0) | output lane 0 |
| 1 | inputs 7:0 | clear change-of-state record |
| 2 | interrupt enable in bit 0 | disable interrupt |
| 3 | filter enable in bit 0 | disable filter |
| 4 | output lane 1 (outputs 15:8) | output lane 1 |
| 5 | inputs 15:8 | no effect |
| 6 | status | no effect |
| 7 | zero | no effect |

A read of address 2 or 3 returns the flag value before the access.

Top module: `iso_dio_regs`

## Requirements
- R1: After reset, `pin_out` is 0, `irq` is 0, `filter_en` is 0 and a read of status (address 6) returns 0x00.
- R2: A write to address 0 loads `pin_out[7:0]` and a write to address 4 loads `pin_out[15:8]`. The new value appears after the write's clock edge. Reads of addresses 0 and 4 return the latched lane, so read-modify-write works.
- R3: A read of address 2 sets interrupt enable and a write of any data to address 2 clears it. Bit 0 of a read of address 2 shows the enable. `irq` is low from the second clock edge after a disabling write.
- R4: A read of address 3 sets `filter_en` after that clock edge, and a write of any data to address 3 clears it. Bit 0 of a read of address 3 shows the flag.
- R5: Reads of address 1 and address 5 return inputs 7:0 and inputs 15:8. The values are taken after a two-flop synchronizer.
- R6: A rising or falling change on any input sets a group bit in status: bit 0 for inputs 7:0 and bit 1 for inputs 15:8. The bit is set at the third clock edge after the pin changes. Group bits are recorded even while the interrupt is disabled.
- R7: Status bit 2 is the pending flag. It is set when a group bit is set while the interrupt is enabled. `irq` equals status bit 2, and status bits 7:3 read as 0.
- R8: A write of any data to address 1 clears the group bits and the pending flag.
- R9: If an input change is detected in the same cycle as a clearing write, the change is kept: its group bit, and the pending flag if the interrupt is enabled, are set after that edge.
- R10: Writes to addresses 5, 6 and 7 change neither outputs, status nor interrupt enable. A read of address 7 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte address |
| bus_rd | input | 1 | Read strobe; side effects at the clock edge |
| bus_wr | input | 1 | Write strobe; has priority over bus_rd |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Asynchronous digital inputs |
| pin_out | output | 16 | Latched digital outputs |
| irq | output | 1 | Level interrupt, equal to the pending flag |
| filter_en | output | 1 | Input filter enable flag |

## Verification
A wrong enable or pending state shows on `irq` within two clock edges of the access that should have changed it. It also shows at once in bit 2 of a status read. A lost or spurious change-of-state event shows up as wrong status group bits, three edges after the pin moves. The clear-versus-new-edge collision is exercised by lining a clearing write up with the exact detection cycle. Ignored writes are checked by reading back outputs, status and enable before any other access.

// File: rtl/iso_dio_pkg.sv
package iso_dio_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      A_OUT_LO = 3'd0,
      A_IN_LO  = 3'd1,
      A_IEN    = 3'd2,
      A_FILT   = 3'd3,
      A_OUT_HI = 3'd4,
      A_IN_HI  = 3'd5,
      A_STAT   = 3'd6,
      A_SPARE  = 3'd7
   } dio_reg_e;

   localparam int STAT_PEND_BIT = 2;
endpackage

// File: rtl/iso_dio_sync.sv
module iso_dio_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out,
   output logic [W-1:0] toggled
);
   if (STAGES < 2) begin : g_bad_stages
      $error("iso_dio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[STAGES-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
   assign toggled  = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/iso_dio_cos.sv
module iso_dio_cos #(
   parameter int W     = 16,
   parameter int GRP_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         toggled,
   input  logic                 clr,
   input  logic                 ien,
   output logic [W/GRP_W-1:0]   grp_q,
   output logic                 pend_q
);
   localparam int NG = W / GRP_W;

   if (NG * GRP_W != W) begin : g_bad_grp
      $error("iso_dio_cos: W must be a multiple of GRP_W");
   end

   logic [NG-1:0] hit;
   logic [NG-1:0] grp_d;

   for (genvar g = 0; g < NG; g++) begin : g_grp
      assign hit[g] = |toggled[g*GRP_W +: GRP_W];
   end

   // a fresh edge wins over a clear in the same cycle
   assign grp_d = clr ? hit : (grp_q | hit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         grp_q  <= grp_d;
         pend_q <= ien & (|grp_d);
      end
   end
endmodule

// File: rtl/iso_dio_outlat.sv
module iso_dio_outlat #(
   parameter int W      = 16,
   parameter int LANE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [W/LANE_W-1:0]   lane_we,
   input  logic [LANE_W-1:0]     wdata,
   output logic [W-1:0]          q
);
   localparam int NL = W / LANE_W;

   if (NL * LANE_W != W) begin : g_bad_lane
      $error("iso_dio_outlat: W must be a multiple of LANE_W");
   end

   for (genvar k = 0; k < NL; k++) begin : g_lane
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          lane_q <= '0;
         else if (lane_we[k]) lane_q <= wdata;
      end
      assign q[k*LANE_W +: LANE_W] = lane_q;
   end
endmodule

// File: rtl/iso_dio_regs.sv
module iso_dio_regs
   import iso_dio_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int IN_W        = 16,
   parameter int OUT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic [IN_W-1:0]   pin_in,
   output logic [OUT_W-1:0]  pin_out,
   output logic              irq,
   output logic              filter_en
);
   localparam int NGRP  = IN_W / BYTE_W;
   localparam int NLANE = OUT_W / BYTE_W;

   if (IN_W != 2*BYTE_W || OUT_W != 2*BYTE_W) begin : g_bad_width
      $error("iso_dio_regs: map holds exactly two byte lanes per direction");
   end
   if (BYTE_W <= STAT_PEND_BIT) begin : g_bad_byte
      $error("iso_dio_regs: BYTE_W too small for status layout");
   end

   // access decode; a write strobe overrides a read strobe
   logic rd_ok;
   assign rd_ok = bus_rd && !bus_wr;

   logic ien_set, ien_clr, filt_set, filt_clr, cos_clr;
   assign ien_set  = rd_ok  && (bus_addr == A_IEN);
   assign ien_clr  = bus_wr && (bus_addr == A_IEN);
   assign filt_set = rd_ok  && (bus_addr == A_FILT);
   assign filt_clr = bus_wr && (bus_addr == A_FILT);
   assign cos_clr  = bus_wr && (bus_addr == A_IN_LO);

   logic ien_q, filt_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q  <= 1'b0;
         filt_q <= 1'b0;
      end else begin
         if (ien_clr)       ien_q <= 1'b0;
         else if (ien_set)  ien_q <= 1'b1;
         if (filt_clr)      filt_q <= 1'b0;
         else if (filt_set) filt_q <= 1'b1;
      end
   end
   assign filter_en = filt_q;

   // output lanes
   logic [NLANE-1:0] lane_we;
   for (genvar k = 0; k < NLANE; k++) begin : g_we
      localparam logic [REG_AW-1:0] LANE_ADDR = (k == 0) ? A_OUT_LO : A_OUT_HI;
      assign lane_we[k] = bus_wr && (bus_addr == LANE_ADDR);
   end

   iso_dio_outlat #(.W(OUT_W), .LANE_W(BYTE_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .wdata   (bus_wdata),
      .q       (pin_out)
   );

   // input path
   logic [IN_W-1:0] in_sync, in_tog;
   iso_dio_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (in_sync),
      .toggled  (in_tog)
   );

   logic [NGRP-1:0] grp;
   logic            pend;
   iso_dio_cos #(.W(IN_W), .GRP_W(BYTE_W)) u_cos (
      .clk     (clk),
      .rst_n   (rst_n),
      .toggled (in_tog),
      .clr     (cos_clr),
      .ien     (ien_q),
      .grp_q   (grp),
      .pend_q  (pend)
   );
   assign irq = pend;

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_OUT_LO: bus_rdata = pin_out[BYTE_W-1:0];
         A_OUT_HI: bus_rdata = pin_out[OUT_W-1:BYTE_W];
         A_IN_LO:  bus_rdata = in_sync[BYTE_W-1:0];
         A_IN_HI:  bus_rdata = in_sync[IN_W-1:BYTE_W];
         A_IEN:    bus_rdata[0] = ien_q;
         A_FILT:   bus_rdata[0] = filt_q;
         A_STAT: begin
            bus_rdata[NGRP-1:0]    = grp;
            bus_rdata[STAT_PEND_BIT] = pend;
         end
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/iso_dio_chk.sv
module iso_dio_chk
   import iso_dio_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int IN_W   = 16,
   parameter int OUT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [BYTE_W-1:0] bus_rdata,
   input logic [OUT_W-1:0]  pin_out,
   input logic              irq,
   input logic              filter_en,
   input logic              ien,
   input logic [IN_W-1:0]   toggled
);
   // R3
   irq_off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_IEN) |=> ##1 !irq);

   // R3
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ien));

   // R4
   filt_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == A_FILT) |=> filter_en);

   // R4
   filt_off_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_FILT) |=> !filter_en);

   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (bus_addr == A_OUT_LO || bus_addr == A_OUT_HI)) |=> $stable(pin_out));

   // R7
   stat_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_STAT) |-> (bus_rdata[STAT_PEND_BIT] == irq && bus_rdata[BYTE_W-1:3] == '0));

   // R8
   clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_IN_LO && toggled == '0) |=> !irq);
endmodule

bind iso_dio_regs iso_dio_chk #(.BYTE_W(BYTE_W), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_rd    (bus_rd),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .irq       (irq),
   .filter_en (filter_en),
   .ien       (ien_q),
   .toggled   (in_tog)
);

// File: tb/iso_dio_regs_bench.sv
module iso_dio_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic        irq;
   logic        filter_en;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   iso_dio_regs u_iso_dio_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .irq(irq), .filter_en(filter_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk("R1 pin_out", pin_out, 16'h0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 filter_en", filter_en, 1'b0);
      bus_read(3'd6, d);
      chk("R1 status", d, 8'h00);
   endtask

   task automatic t_outputs;
      logic [7:0] d;
      bus_write(3'd0, 8'hA5);
      chk("R2 lane0 drive", pin_out, 16'h00A5);
      bus_write(3'd4, 8'h3C);
      chk("R2 lane1 drive", pin_out, 16'h3CA5);
      bus_read(3'd0, d);
      chk("R2 lane0 readback", d, 8'hA5);
      bus_read(3'd4, d);
      chk("R2 lane1 readback", d, 8'h3C);
      bus_read(3'd0, d);
      bus_write(3'd0, d | 8'h02);
      chk("R2 read-modify-write", pin_out, 16'h3CA7);
   endtask

   task automatic t_filter;
      logic [7:0] d;
      bus_read(3'd3, d);
      chk("R4 read sets filter", filter_en, 1'b1);
      bus_read(3'd3, d);
      chk("R4 read shows flag", d, 8'h01);
      bus_write(3'd3, 8'hFF);
      chk("R4 write clears filter", filter_en, 1'b0);
   endtask

   task automatic t_inputs;
      logic [7:0] d;
      pin_in = 16'h5A81;
      idle(3);
      bus_read(3'd1, d);
      chk("R5 inputs low", d, 8'h81);
      bus_read(3'd5, d);
      chk("R5 inputs high", d, 8'h5A);
      bus_read(3'd6, d);
      chk("R6 groups recorded while disabled", d, 8'h03);
      chk("R7 no irq while disabled", irq, 1'b0);
      bus_write(3'd1, 8'h5A);
      bus_read(3'd6, d);
      chk("R8 clear with data", d, 8'h00);
   endtask

   task automatic t_events;
      logic [7:0] d;
      bus_read(3'd2, d);
      chk("R3 enable read shows old", d, 8'h00);
      bus_read(3'd2, d);
      chk("R3 enable set by read", d, 8'h01);
      pin_in = 16'h5A89;
      idle(2);
      chk("R6 not yet at second edge", irq, 1'b0);
      idle(1);
      chk("R6 rising low group irq", irq, 1'b1);
      bus_read(3'd6, d);
      chk("R7 status low group pending", d, 8'h05);
      bus_write(3'd1, 8'h00);
      chk("R8 clear drops irq", irq, 1'b0);
      pin_in = 16'h1A89;
      idle(3);
      bus_read(3'd6, d);
      chk("R6 falling high group", d, 8'h06);
      bus_write(3'd1, 8'hFF);
      bus_read(3'd6, d);
      chk("R8 clear status", d, 8'h00);
   endtask

   task automatic t_disable;
      logic [7:0] d;
      pin_in = 16'h1A88;
      idle(3);
      chk("R7 irq before disable", irq, 1'b1);
      bus_write(3'd2, 8'hFF);
      idle(1);
      chk("R3 irq low after disable", irq, 1'b0);
      bus_read(3'd6, d);
      chk("R3 group kept pending cleared", d, 8'h01);
      bus_read(3'd2, d);
      idle(1);
      chk("R3 re-enable raises irq", irq, 1'b1);
      bus_write(3'd1, 8'h00);
   endtask

   task automatic t_collide;
      logic [7:0] d;
      pin_in = 16'h1A08;
      repeat (2) @(posedge clk);
      @(negedge clk);
      bus_write(3'd1, 8'h00);
      bus_read(3'd6, d);
      chk("R9 edge survives clear", d, 8'h05);
      chk("R9 irq survives clear", irq, 1'b1);
      bus_write(3'd1, 8'h00);
      chk("R8 later clear", irq, 1'b0);
   endtask

   task automatic t_ignored;
      logic [7:0] d;
      bus_write(3'd5, 8'hFF);
      bus_write(3'd6, 8'hFF);
      bus_write(3'd7, 8'hFF);
      chk("R10 outputs unchanged", pin_out, 16'h3CA7);
      bus_read(3'd6, d);
      chk("R10 status unchanged", d, 8'h00);
      bus_read(3'd2, d);
      chk("R10 enable unchanged", d, 8'h01);
      bus_read(3'd7, d);
      chk("R10 spare reads zero", d, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_outputs();
      t_filter();
      t_inputs();
      t_events();
      t_disable();
      t_collide();
      t_ignored();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule